// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Front End

This block is a synthesizable model of the synchronous front end of a double-data-rate SRAM with a small internal array. Each storage location holds a pair of words, and every access moves both words of the pair. Reads and writes share one address bus. Rising edges of the input clock `k` alternate between read slots and write slots. In a read slot, an active-low read strobe starts a read of the addressed pair. In a write slot, an active-low write strobe starts a write. The two write words arrive on consecutive edges of `k`, and the two read words leave on consecutive edges of `k`.

A parameter selects where a burst starts. In fixed-start mode the burst always begins at word 0 of the pair and the whole address selects the location. In address-LSB mode the upper address bits select the location, the address LSB selects the first word, and the burst then moves to the other word. Read data appears after a fixed latency, counted in half cycles. An output-enable flag marks the half cycles in which the read bus is driven. The echo clocks follow the input clock so that a receiver can capture the read words with them.

Top module: `dual_edge_burst_sram`

## Requirements
- R1: While `rst_n` is low, `q_en` is low and `q` is all zeros. The first rising edge of `k` after release is a read slot, and the slots then alternate read, write, read. Reset does not clear the array.
- R2: `rd_n` low is honoured only at a read-slot rising edge, and `wr_n` low only at a write-slot rising edge. A strobe in the other slot starts nothing and leaves the array unchanged.
- R3: A write takes its first word from `d` at the write-slot rising edge of `k` and its second word at the falling edge that follows.
- R4: With `START_FROM_LSB` = 0, the full address selects the location. The first written word goes to word index 0 and the second to index 1. A read returns index 0 first, then index 1.
- R5: With `START_FROM_LSB` = 1, address bits [ADDR_W-1:1] select the location. The first written word goes to word index `addr[0]` and the second to the other index. A read returns word `addr[0]` first, then the other word.
- R6: The first read word is on `q` during the low phase of `k` that begins `RD_LAT_HALF` half cycles (default 3, so 1.5 cycles) after the read-slot rising edge. The second read word is on `q` during the high phase that follows.
- R7: `q_en` is high only during the two half cycles of a read burst. Whenever `q_en` is low, `q` is all zeros.
- R8: A slot in which neither strobe is honoured changes neither the array nor the outputs.
- R9: A read in the slot right after a write to the same location returns the newly written words.
- R10: A write in the slot right after a read of the same location does not change the data that read returns.
- R11: `cq` equals `k` and `cq_n` is its inverse at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k | input | 1 | Input clock. Rising edges alternate between read and write slots. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| rd_n | input | 1 | Active-low read strobe, sampled in read slots. |
| wr_n | input | 1 | Active-low write strobe, sampled in write slots. |
| addr | input | ADDR_W | Shared address for reads and writes. |
| d | input | DATA_W | Write data, sampled on both edges of `k` during a write. |
| q | output | DATA_W | Read data, one word per half cycle. Zero when idle. |
| q_en | output | 1 | Drive enable for the shared data pins. High only during a read burst. |
| cq | output | 1 | Echo clock in phase with `k`. |
| cq_n | output | 1 | Inverted echo clock. |

## Verification
The bench goes after the ordering corner cases. A write followed at once by a read of the same location must return the new words; a design that commits the write too late returns stale data there. A read followed at once by a write must still return the old words; a design that forwards too eagerly returns the new data instead. In address-LSB mode the bench reads from odd addresses and writes to the odd partner of an even address. A burst counter that ignores the LSB, or that loads it on only one side, shows up as swapped words. The bench also places strobes in the wrong slot and issues fully idle slots, then reads back. A design that decodes the strobes without regard to the slot corrupts memory or drives the bus when it should not.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  // Slot kind for the rising edge currently being processed.
  typedef enum logic {
    SLOT_RD = 1'b0,
    SLOT_WR = 1'b1
  } slot_e;

  // Index of the word a burst starts from.
  function automatic logic first_word(input bit lsb_mode, input logic addr_lsb);
    return lsb_mode ? addr_lsb : 1'b0;
  endfunction

  // Whole rising edges from the read-slot edge to the final pre-launch
  // edge, for an odd latency given in half cycles.
  function automatic int fetch_stages(input int lat_half);
    return (lat_half - 1) / 2;
  endfunction

endpackage

// File: rtl/bsram_slot_ctl.sv
module bsram_slot_ctl #(
  parameter int ADDR_W         = 6,
  parameter bit START_FROM_LSB = 1'b1,
  localparam int SHIFT         = START_FROM_LSB ? 1 : 0,
  localparam int PAIR_W        = ADDR_W - SHIFT
) (
  input  logic              k,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_slot,
  output logic              rd_accept,
  output logic              wr_accept,
  output logic              rd_cap_v,
  output logic [PAIR_W-1:0] rd_cap_pair,
  output logic              rd_cap_first,
  output logic              wr_cap_v,
  output logic [PAIR_W-1:0] wr_cap_pair,
  output logic              wr_cap_first
);
  import bsram_pkg::*;

  slot_e             phase;
  logic [PAIR_W-1:0] pair_now;
  logic              first_now;

  assign rd_slot   = (phase == SLOT_RD);
  assign rd_accept = rd_slot & ~rd_n;
  assign wr_accept = ~rd_slot & ~wr_n;
  assign pair_now  = PAIR_W'(addr >> SHIFT);
  assign first_now = first_word(START_FROM_LSB, addr[0]);

  always_ff @(posedge k or negedge rst_n) begin
    if (!rst_n) begin
      phase <= SLOT_RD;
    end else begin
      phase <= rd_slot ? SLOT_WR : SLOT_RD;
    end
  end

  always_ff @(posedge k or negedge rst_n) begin
    if (!rst_n) begin
      rd_cap_v     <= 1'b0;
      rd_cap_pair  <= '0;
      rd_cap_first <= 1'b0;
      wr_cap_v     <= 1'b0;
      wr_cap_pair  <= '0;
      wr_cap_first <= 1'b0;
    end else begin
      rd_cap_v <= rd_accept;
      wr_cap_v <= wr_accept;
      if (rd_accept) begin
        rd_cap_pair  <= pair_now;
        rd_cap_first <= first_now;
      end
      if (wr_accept) begin
        wr_cap_pair  <= pair_now;
        wr_cap_first <= first_now;
      end
    end
  end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int PAIR_W = 5,
  parameter int DATA_W = 18,
  localparam int NPAIR = 1 << PAIR_W
) (
  input  logic              k,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d,
  input  logic              wr_accept,
  input  logic              wr_cap_v,
  input  logic [PAIR_W-1:0] wr_cap_pair,
  input  logic              wr_cap_first,
  input  logic              rd_cap_v,
  input  logic [PAIR_W-1:0] rd_cap_pair,
  input  logic              rd_cap_first,
  output logic              wr_commit,
  output logic              rd_fetch,
  output logic              fetch_v,
  output logic [DATA_W-1:0] fetch_w0,
  output logic [DATA_W-1:0] fetch_w1
);
  logic [DATA_W-1:0] mem [NPAIR][2];
  logic [DATA_W-1:0] word_a;
  logic [DATA_W-1:0] word_b;

  // The pair is committed at the rising edge after the write slot; the
  // pending read of the slot before it has already fetched by then.
  assign wr_commit = wr_cap_v;
  assign rd_fetch  = rd_cap_v;

  always_ff @(posedge k or negedge rst_n) begin
    if (!rst_n) begin
      word_a  <= '0;
      fetch_v <= 1'b0;
    end else begin
      if (wr_accept) word_a <= d;
      fetch_v <= rd_cap_v;
    end
  end

  // The second write word is taken on the falling edge inside the write.
  always_ff @(negedge k or negedge rst_n) begin
    if (!rst_n) begin
      word_b <= '0;
    end else if (wr_cap_v) begin
      word_b <= d;
    end
  end

  always_ff @(posedge k) begin
    if (wr_commit) begin
      mem[wr_cap_pair][wr_cap_first]  <= word_a;
      mem[wr_cap_pair][~wr_cap_first] <= word_b;
    end
    if (rd_fetch) begin
      fetch_w0 <= mem[rd_cap_pair][rd_cap_first];
      fetch_w1 <= mem[rd_cap_pair][~rd_cap_first];
    end
  end

endmodule

// File: rtl/bsram_rd_launch.sv
module bsram_rd_launch #(
  parameter int DATA_W      = 18,
  parameter int RD_LAT_HALF = 3,
  localparam int NDELAY     = bsram_pkg::fetch_stages(RD_LAT_HALF) - 1
) (
  input  logic              k,
  input  logic              rst_n,
  input  logic              fetch_v,
  input  logic [DATA_W-1:0] fetch_w0,
  input  logic [DATA_W-1:0] fetch_w1,
  output logic [DATA_W-1:0] q,
  output logic              q_en
);
  logic              tail_v;
  logic [DATA_W-1:0] tail_w0;
  logic [DATA_W-1:0] tail_w1;
  logic              en_fall;
  logic              en_rise;
  logic [DATA_W-1:0] q_fall;
  logic [DATA_W-1:0] q_rise;

  if (NDELAY == 0) begin : g_direct
    assign tail_v  = fetch_v;
    assign tail_w0 = fetch_w0;
    assign tail_w1 = fetch_w1;
  end else begin : g_delay
    logic              dv  [NDELAY];
    logic [DATA_W-1:0] dw0 [NDELAY];
    logic [DATA_W-1:0] dw1 [NDELAY];

    always_ff @(posedge k or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NDELAY; i++) begin
          dv[i]  <= 1'b0;
          dw0[i] <= '0;
          dw1[i] <= '0;
        end
      end else begin
        dv[0]  <= fetch_v;
        dw0[0] <= fetch_w0;
        dw1[0] <= fetch_w1;
        for (int i = 1; i < NDELAY; i++) begin
          dv[i]  <= dv[i-1];
          dw0[i] <= dw0[i-1];
          dw1[i] <= dw1[i-1];
        end
      end
    end

    assign tail_v  = dv[NDELAY-1];
    assign tail_w0 = dw0[NDELAY-1];
    assign tail_w1 = dw1[NDELAY-1];
  end

  always_ff @(negedge k or negedge rst_n) begin
    if (!rst_n) begin
      en_fall <= 1'b0;
      q_fall  <= '0;
    end else begin
      en_fall <= tail_v;
      q_fall  <= tail_v ? tail_w0 : '0;
    end
  end

  always_ff @(posedge k or negedge rst_n) begin
    if (!rst_n) begin
      en_rise <= 1'b0;
      q_rise  <= '0;
    end else begin
      en_rise <= tail_v;
      q_rise  <= tail_v ? tail_w1 : '0;
    end
  end

  // The high phase shows the rise-launched word, the low phase the other.
  assign q    = k ? q_rise : q_fall;
  assign q_en = k ? en_rise : en_fall;

endmodule

// File: rtl/dual_edge_burst_sram.sv
module dual_edge_burst_sram #(
  parameter int ADDR_W         = 6,
  parameter int DATA_W         = 18,
  parameter bit START_FROM_LSB = 1'b1,
  parameter int RD_LAT_HALF    = 3,
  localparam int PAIR_W        = START_FROM_LSB ? ADDR_W - 1 : ADDR_W
) (
  input  logic              k,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              q_en,
  output logic              cq,
  output logic              cq_n
);
  logic              rd_slot;
  logic              rd_accept;
  logic              wr_accept;
  logic              rd_cap_v;
  logic [PAIR_W-1:0] rd_cap_pair;
  logic              rd_cap_first;
  logic              wr_cap_v;
  logic [PAIR_W-1:0] wr_cap_pair;
  logic              wr_cap_first;
  logic              wr_commit;
  logic              rd_fetch;
  logic              fetch_v;
  logic [DATA_W-1:0] fetch_w0;
  logic [DATA_W-1:0] fetch_w1;

  bsram_slot_ctl #(
    .ADDR_W(ADDR_W),
    .START_FROM_LSB(START_FROM_LSB)
  ) u_slot (
    .k(k), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .rd_slot(rd_slot), .rd_accept(rd_accept), .wr_accept(wr_accept),
    .rd_cap_v(rd_cap_v), .rd_cap_pair(rd_cap_pair), .rd_cap_first(rd_cap_first),
    .wr_cap_v(wr_cap_v), .wr_cap_pair(wr_cap_pair), .wr_cap_first(wr_cap_first)
  );

  bsram_array #(
    .PAIR_W(PAIR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .k(k), .rst_n(rst_n), .d(d), .wr_accept(wr_accept),
    .wr_cap_v(wr_cap_v), .wr_cap_pair(wr_cap_pair), .wr_cap_first(wr_cap_first),
    .rd_cap_v(rd_cap_v), .rd_cap_pair(rd_cap_pair), .rd_cap_first(rd_cap_first),
    .wr_commit(wr_commit), .rd_fetch(rd_fetch),
    .fetch_v(fetch_v), .fetch_w0(fetch_w0), .fetch_w1(fetch_w1)
  );

  bsram_rd_launch #(
    .DATA_W(DATA_W),
    .RD_LAT_HALF(RD_LAT_HALF)
  ) u_launch (
    .k(k), .rst_n(rst_n), .fetch_v(fetch_v),
    .fetch_w0(fetch_w0), .fetch_w1(fetch_w1),
    .q(q), .q_en(q_en)
  );

  assign cq   = k;
  assign cq_n = ~k;

endmodule

// File: rtl/bsram_checker.sv
module bsram_checker (
  input logic k,
  input logic rst_n,
  input logic rd_slot,
  input logic rd_accept,
  input logic wr_accept,
  input logic wr_commit,
  input logic rd_fetch
);

  // R1: slots strictly alternate after reset
  assert_slot_alternates_R1: assert property (@(posedge k) disable iff (!rst_n)
    rd_slot |=> !rd_slot);
  assert_slot_returns_R1: assert property (@(posedge k) disable iff (!rst_n)
    !rd_slot |=> rd_slot);

  // R3: an accepted write is committed on the next rising edge
  assert_wr_commit_R3: assert property (@(posedge k) disable iff (!rst_n)
    wr_accept |=> wr_commit);

  // R6: an accepted read fetches the array on the next rising edge
  assert_rd_fetch_R6: assert property (@(posedge k) disable iff (!rst_n)
    rd_accept |=> rd_fetch);

  // R9: commit and fetch never share an edge, so ordering is by slot
  assert_commit_fetch_apart_R9: assert property (@(posedge k) disable iff (!rst_n)
    wr_commit |-> !rd_fetch);

  // R7: fetches are spaced so bursts never overlap
  assert_fetch_spacing_R7: assert property (@(posedge k) disable iff (!rst_n)
    rd_fetch |=> !rd_fetch);

endmodule

bind dual_edge_burst_sram bsram_checker u_chk (
  .k(k), .rst_n(rst_n), .rd_slot(rd_slot), .rd_accept(rd_accept),
  .wr_accept(wr_accept), .wr_commit(wr_commit), .rd_fetch(rd_fetch)
);

// File: tb/dual_edge_burst_sram_test.sv
module dual_edge_burst_sram_test;
  localparam int AW = 6;
  localparam int DW = 18;

  logic k = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1;
  logic wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;

  wire [DW-1:0] q_l, q_f;
  wire qen_l, qen_f, cq_l, cqn_l, cq_f, cqn_f;

  int checks = 0;
  int fails = 0;

  // Models: address-LSB mode keyed by addr[5:1], fixed mode by addr
  logic [DW-1:0] ml [32][2];
  bit            mlv [32];
  logic [DW-1:0] mf [64][2];
  bit            mfv [64];

  // {rd, wr, raddr[5:0], waddr[5:0]}
  localparam logic [13:0] VEC [8] = '{
    14'h1004, 14'h310B, 14'h3160, 14'h3285,
    14'h3104, 14'h2100, 14'h32FF, 14'h2F80
  };

  dual_edge_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .START_FROM_LSB(1'b1), .RD_LAT_HALF(3)) uut (
    .k(k), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .d(d),
    .q(q_l), .q_en(qen_l), .cq(cq_l), .cq_n(cqn_l));

  dual_edge_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .START_FROM_LSB(1'b0), .RD_LAT_HALF(3)) uut_fixed (
    .k(k), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .d(d),
    .q(q_f), .q_en(qen_f), .cq(cq_f), .cq_n(cqn_f));

  always #4 k = ~k;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Burst window relative to the falling edge before the read slot.
  task automatic watch(input bit rd, input bit lok, input bit fok,
                       input logic [DW-1:0] l0, l1, f0, f1, input string tag);
    fork
      begin
        #18;
        if (rd) begin
          if (lok) chk(qen_l === 1'b1 && q_l === l0, {tag, "/R6"}, q_l, l0);
          if (fok) chk(qen_f === 1'b1 && q_f === f0, "R4/R6", q_f, f0);
        end else begin
          chk(qen_l === 1'b0 && qen_f === 1'b0, tag, DW'(qen_l), '0);
        end
        #4;
        if (rd) begin
          if (lok) chk(qen_l === 1'b1 && q_l === l1, tag, q_l, l1);
          if (fok) chk(qen_f === 1'b1 && q_f === f1, "R4", q_f, f1);
        end else begin
          chk(qen_l === 1'b0 && qen_f === 1'b0, tag, DW'(qen_f), '0);
        end
        #4;
        chk(qen_l === 1'b0 && q_l === '0, "R7", q_l, '0);
        chk(qen_f === 1'b0 && q_f === '0, "R7", q_f, '0);
      end
    join_none
  endtask

  // One read slot then one write slot; starts and ends at a falling edge
  // that precedes a read slot. Flags are active-high strobe requests.
  task automatic slot_pair(input bit rd_in_rd, input bit wr_in_rd,
                           input bit rd_in_wr, input bit wr_in_wr,
                           input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                           input logic [DW-1:0] a, input logic [DW-1:0] b,
                           input string tag);
    logic [DW-1:0] l0, l1, f0, f1;
    bit lok, fok;
    l0 = ml[ra[5:1]][ra[0]];
    l1 = ml[ra[5:1]][~ra[0]];
    f0 = mf[ra][0];
    f1 = mf[ra][1];
    lok = mlv[ra[5:1]];
    fok = mfv[ra];
    watch(rd_in_rd, lok, fok, l0, l1, f0, f1, tag);
    rd_n = ~rd_in_rd;
    wr_n = ~wr_in_rd;
    addr = ra;
    @(negedge k);
    rd_n = ~rd_in_wr;
    wr_n = ~wr_in_wr;
    addr = wa;
    d = a;
    @(posedge k);
    #2 d = b;
    @(negedge k);
    rd_n = 1'b1;
    wr_n = 1'b1;
    if (wr_in_wr) begin
      ml[wa[5:1]][wa[0]]  = a;
      ml[wa[5:1]][~wa[0]] = b;
      mlv[wa[5:1]] = 1'b1;
      mf[wa][0] = a;
      mf[wa][1] = b;
      mfv[wa] = 1'b1;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state in both clock phases
    repeat (3) @(negedge k);
    #2 chk(qen_l === 1'b0 && q_l === '0, "R1", q_l, '0);
    chk(qen_f === 1'b0 && q_f === '0, "R1", q_f, '0);
    #4 chk(qen_l === 1'b0 && q_l === '0, "R1", q_l, '0);
    @(negedge k);
    rst_n = 1'b1;

    // Table walk: mixed writes and reads, odd and even addresses (R5, R4)
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] a;
      a = DW'(i * 18'h2345 + 18'h00A5);
      slot_pair(VEC[i][13], 1'b0, 1'b0, VEC[i][12], VEC[i][11:6], VEC[i][5:0], a, ~a, "R5");
    end

    // R9: write then read of the same location in the next slot
    slot_pair(1'b0, 1'b0, 1'b0, 1'b1, 6'h00, 6'h30, 18'h12345, 18'h2ABCD, "R7");
    slot_pair(1'b1, 1'b0, 1'b0, 1'b0, 6'h30, 6'h00, '0, '0, "R9");

    // R3: the second word is the one on d at the falling edge
    slot_pair(1'b0, 1'b0, 1'b0, 1'b1, 6'h00, 6'h31, 18'h0F0F0, 18'h30303, "R7");
    slot_pair(1'b1, 1'b0, 1'b0, 1'b0, 6'h30, 6'h00, '0, '0, "R3");

    // R10: read then write of the same location; the read sees old data
    slot_pair(1'b1, 1'b0, 1'b0, 1'b1, 6'h30, 6'h30, 18'h1111F, 18'h2222E, "R10");
    slot_pair(1'b1, 1'b0, 1'b0, 1'b0, 6'h30, 6'h00, '0, '0, "R10");

    // R2: strobes in the wrong slots are ignored
    slot_pair(1'b0, 1'b1, 1'b1, 1'b0, 6'h30, 6'h30, 18'h3DEAD, 18'h0BEEF, "R2");
    slot_pair(1'b1, 1'b0, 1'b0, 1'b0, 6'h30, 6'h00, '0, '0, "R2");

    // R8: fully idle slots with active data change nothing
    slot_pair(1'b0, 1'b0, 1'b0, 1'b0, 6'h30, 6'h30, 18'h15555, 18'h2AAAA, "R8");
    slot_pair(1'b1, 1'b0, 1'b0, 1'b0, 6'h30, 6'h00, '0, '0, "R8");

    // R11: echo clocks follow k
    slot_pair(1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, '0, '0, "R8");
    #2 chk(cq_l === 1'b0 && cqn_l === 1'b1, "R11", DW'(cq_l), '0);
    #4 chk(cq_l === 1'b1 && cqn_l === 1'b0, "R11", DW'(cq_l), 18'h1);
    @(negedge k);

    // R1: reset mid-run, alignment restarts on a read slot, array kept
    slot_pair(1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, '0, '0, "R8");
    rst_n = 1'b0;
    #6 chk(qen_l === 1'b0 && q_l === '0, "R1", q_l, '0);
    @(negedge k);
    @(negedge k);
    rst_n = 1'b1;
    slot_pair(1'b1, 1'b0, 1'b0, 1'b0, 6'h30, 6'h00, '0, '0, "R1");
    slot_pair(1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h00, '0, '0, "R7");

    #40;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule